// File: doc/BRIEF.md
# Extended-Precision Value Classifier

This block takes one 80-bit extended-precision register value and the tag bit that says whether the register is empty. It returns a 3-bit class code on the flags C3, C2 and C0, and the value's sign on C1. A stack unit uses it to answer a "what kind of number is on top" query. The block does not read the stack and does not write any status word. Classification never raises a floating-point exception. There is no exception output at all, and every encoding maps to exactly one of seven codes.

The value is split into four fields:

| Bits | Field |
|------|-------|
| 79 | sign |
| 78:64 | biased exponent |
| 63 | explicit integer bit |
| 62:0 | fraction |

The decode itself is combinational. It feeds a registered output stage driven by a two-state machine:

- `OS_IDLE`: nothing new is on the outputs.
- `OS_SHOW`: a fresh result is on the outputs.

Transitions:

- **accept**: `OS_IDLE` to `OS_SHOW` when `in_valid` is 1.
- **stream**: `OS_SHOW` to `OS_SHOW` when `in_valid` is 1.
- **drain**: `OS_SHOW` to `OS_IDLE` when `in_valid` is 0.
- **wait**: `OS_IDLE` to `OS_IDLE` when `in_valid` is 0.

The flags change only on a clock edge where `in_valid` is 1. Between requests they keep the last result.

Top module: `xcls_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and all four flag outputs are 0.
- R2: When `in_empty` is 1, the code {C3,C2,C0} is 101, whatever the value bits are.
- R3: C1 equals bit 79 of the accepted value (0 means positive, 1 means negative). This holds for empty registers too.
- R4: An exponent of 0 with bits 63:0 all zero gives code 100 (zero).
- R5: An exponent of 0 with bits 63:0 nonzero gives code 110 (denormal). This includes the case where bit 63 is set.
- R6: An exponent of all ones with bit 63 set and fraction 0 gives code 011 (infinity).
- R7: An exponent of all ones with bit 63 set and fraction nonzero gives code 001 (NaN).
- R8: A nonzero exponent below all ones with bit 63 set gives code 010 (normal).
- R9: A nonzero exponent with bit 63 clear gives code 000 (unsupported).
- R10: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and the result appears in that same cycle.
- R11: While `in_valid` is 0, the flag outputs keep their previous values.
- R12: The code 111 is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_empty | input | 1 | Tag: 1 when the register is empty |
| in_value | input | 80 | Register contents |
| out_valid | output | 1 | A new result is on the flags |
| out_c3 | output | 1 | Class code, high bit |
| out_c2 | output | 1 | Class code, middle bit |
| out_c1 | output | 1 | Sign of the accepted value |
| out_c0 | output | 1 | Class code, low bit |

## Verification
A wrong state in the output machine shows up on `out_valid` one cycle after the bad transition. This happens either as a missing pulse after a request or as a stray pulse after an idle cycle. A wrong capture enable shows up in the first idle cycle, because the flags then change when they should hold. Decode errors show at the port in the cycle after the offending value: a wrong code or a wrong sign. The bench compares every cycle against its model, so the first wrong cycle is reported.

// File: rtl/xcls_pkg.sv
package xcls_pkg;

    // Class codes on {C3,C2,C0}
    typedef enum logic [2:0] {
        CLS_UNSUP  = 3'b000,
        CLS_NAN    = 3'b001,
        CLS_NORM   = 3'b010,
        CLS_INF    = 3'b011,
        CLS_ZERO   = 3'b100,
        CLS_EMPTY  = 3'b101,
        CLS_DENORM = 3'b110
    } cls_e;

    // Field features extracted from a value
    typedef struct packed {
        logic exp_zero;
        logic exp_max;
        logic int_bit;
        logic frac_zero;
    } feat_t;

    typedef enum logic {
        OS_IDLE,
        OS_SHOW
    } ostate_e;

endpackage

// File: rtl/xcls_zdet.sv
// Zero detector built from chunked NOR reductions, one per chunk, joined by an AND.
module xcls_zdet #(
    parameter int W     = 63,
    parameter int CHUNK = 16
) (
    input  logic [W-1:0] vec,
    output logic         is_zero
);
    localparam int NCH  = (W + CHUNK - 1) / CHUNK;
    localparam int PADW = NCH * CHUNK;

    logic [PADW-1:0] pad;
    logic [NCH-1:0]  part;

    always_comb begin
        pad        = '0;
        pad[W-1:0] = vec;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chunk
            assign part[gi] = ~|pad[gi*CHUNK +: CHUNK];
        end
    endgenerate

    assign is_zero = &part;
endmodule

// File: rtl/xcls_decode.sv
// Splits a value into sign and field features.
module xcls_decode
    import xcls_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 63,
    parameter int CHUNK  = 16
) (
    input  logic [EXP_W+FRAC_W+1:0] value,
    output logic                    sign,
    output feat_t                   feat
);
    localparam int W = EXP_W + FRAC_W + 2;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              e_zero;
    logic              e_ones;
    logic              f_zero;

    assign sign   = value[W-1];
    assign exp_f  = value[W-2 -: EXP_W];
    assign frac_f = value[FRAC_W-1:0];

    xcls_zdet #(.W(EXP_W), .CHUNK(CHUNK)) u_ezero (
        .vec     (exp_f),
        .is_zero (e_zero)
    );

    xcls_zdet #(.W(EXP_W), .CHUNK(CHUNK)) u_eones (
        .vec     (~exp_f),
        .is_zero (e_ones)
    );

    xcls_zdet #(.W(FRAC_W), .CHUNK(CHUNK)) u_fzero (
        .vec     (frac_f),
        .is_zero (f_zero)
    );

    always_comb begin
        feat.exp_zero  = e_zero;
        feat.exp_max   = e_ones;
        feat.int_bit   = value[FRAC_W];
        feat.frac_zero = f_zero;
    end
endmodule

// File: rtl/xcls_select.sv
// Maps the empty tag and field features onto one of seven classes.
module xcls_select
    import xcls_pkg::*;
(
    input  logic  empty,
    input  feat_t feat,
    output cls_e  cls
);
    always_comb begin
        if (empty) begin
            cls = CLS_EMPTY;
        end else if (feat.exp_zero) begin
            cls = (!feat.int_bit && feat.frac_zero) ? CLS_ZERO : CLS_DENORM;
        end else if (!feat.int_bit) begin
            cls = CLS_UNSUP;
        end else if (feat.exp_max) begin
            cls = feat.frac_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/xcls_top.sv
module xcls_top
    import xcls_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int FRAC_W = 63,
    parameter int CHUNK  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_empty,
    input  logic [EXP_W+FRAC_W+1:0] in_value,
    output logic                    out_valid,
    output logic                    out_c3,
    output logic                    out_c2,
    output logic                    out_c1,
    output logic                    out_c0
);
    localparam int W = EXP_W + FRAC_W + 2;

    logic    sign_w;
    feat_t   feat_w;
    cls_e    cls_w;
    ostate_e state_q;
    ostate_e state_d;
    cls_e    cls_q;
    logic    sign_q;

    xcls_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CHUNK(CHUNK)) u_dec (
        .value (in_value),
        .sign  (sign_w),
        .feat  (feat_w)
    );

    xcls_select u_sel (
        .empty (in_empty),
        .feat  (feat_w),
        .cls   (cls_w)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: state_d = in_valid ? OS_SHOW : OS_IDLE;
            OS_SHOW: state_d = in_valid ? OS_SHOW : OS_IDLE;
            default: state_d = OS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output capture: load only on an accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q  <= CLS_UNSUP;
            sign_q <= 1'b0;
        end else if (in_valid) begin
            cls_q  <= cls_w;
            sign_q <= sign_w;
        end
    end

    assign out_valid = (state_q == OS_SHOW);
    assign out_c3    = cls_q[2];
    assign out_c2    = cls_q[1];
    assign out_c0    = cls_q[0];
    assign out_c1    = sign_q;
endmodule

// File: rtl/xcls_chk.sv
module xcls_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_empty,
    input logic in_sign,
    input logic out_valid,
    input logic out_c3,
    input logic out_c2,
    input logic out_c1,
    input logic out_c0
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_empty) |=> ({out_c3, out_c2, out_c0} == 3'b101)); // R2

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_c1 == $past(in_sign))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({out_c3, out_c2, out_c1, out_c0})); // R11

    AST_NO_CODE_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({out_c3, out_c2, out_c0} != 3'b111)); // R12

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!out_valid); // R1
        end
    end
endmodule

bind xcls_top xcls_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_empty  (in_empty),
    .in_sign   (in_value[W-1]),
    .out_valid (out_valid),
    .out_c3    (out_c3),
    .out_c2    (out_c2),
    .out_c1    (out_c1),
    .out_c0    (out_c0)
);

// File: tb/sim_xcls_top.sv
`timescale 1ns/1ps
module sim_xcls_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_empty = 1'b0;
    logic [79:0] in_value = '0;
    logic        out_valid, out_c3, out_c2, out_c1, out_c0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Model state: what the outputs must show after the next edge
    int m_valid = 0;
    int m_code  = 0;
    int m_sign  = 0;

    always #2.5 clk = ~clk;

    xcls_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_empty  (in_empty),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_c3    (out_c3),
        .out_c2    (out_c2),
        .out_c1    (out_c1),
        .out_c0    (out_c0)
    );

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int ref_cls(input bit empty, input logic [79:0] v);
        int e;
        e = int'(v[78:64]);
        if (empty) return 5;
        if (e == 0) return (v[63:0] == 64'd0) ? 4 : 6;
        if (!v[63]) return 0;
        if (e == 32767) return (v[62:0] == 63'd0) ? 3 : 1;
        return 2;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0: return "R9";
            1: return "R7";
            2: return "R8";
            3: return "R6";
            4: return "R4";
            5: return "R2";
            6: return "R5";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [79:0] build(input int kind);
        logic [62:0] fr;
        logic [14:0] ex;
        logic        s;
        fr = {$urandom, $urandom};
        ex = 15'($urandom);
        s  = 1'($urandom);
        case (kind)
            0: return {s, 15'd0, 1'b0, 63'd0};                 // zero
            1: return {s, 15'd0, 1'b0, fr | 63'd1};            // denormal
            2: return {s, 15'd0, 1'b1, fr};                    // pseudo-denormal
            3: return {s, 15'h7FFF, 1'b1, 63'd0};              // infinity
            4: return {s, 15'h7FFF, 1'b1, fr | 63'd4};         // NaN
            5: return {s, (ex == 15'd0 || ex == 15'h7FFF) ? 15'd1 : ex, 1'b1, fr};
            6: return {s, 15'h7FFE, 1'b1, fr};                 // normal, top exponent
            7: return {s, ex | 15'd1, 1'b0, fr};               // unsupported
            8: return {s, 15'h7FFF, 1'b0, 63'd0};              // unsupported at max
            default: return {s, ex, 1'($urandom), fr};         // anything
        endcase
    endfunction

    initial begin : watchdog
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 code", int'({out_c3, out_c2, out_c0}), 0);
        chk("R1 sign", int'(out_c1), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 800; cyc++) begin
            @(negedge clk);
            // Compare against the model
            chk("R10 valid", int'(out_valid), m_valid);
            chk(tag_of(m_code), int'({out_c3, out_c2, out_c0}), m_code);
            chk("R3 sign", int'(out_c1), m_sign);
            if (int'({out_c3, out_c2, out_c0}) == 7) chk("R12", 7, 0);
            // Drive the next request (R11: idle cycles carry garbage)
            in_valid = ((cyc % 5) != 4) && (cyc % 37 != 20);
            in_empty = (cyc % 11 == 3) || ((cyc % 29) == 7);
            in_value = build(cyc % 10);
            if (in_valid) begin
                m_valid = 1;
                m_code  = ref_cls(in_empty, in_value);
                m_sign  = int'(in_value[79]);
            end else begin
                m_valid = 0;
            end
        end
        @(negedge clk);
        chk("R10 valid", int'(out_valid), m_valid);
        chk(tag_of(m_code), int'({out_c3, out_c2, out_c0}), m_code);
        chk("R3 sign", int'(out_c1), m_sign);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule